// File: doc/BRIEF.md
# Packet Head Trace Matcher

This block sits on one receive port of a packet switch. It watches the incoming 32-bit word stream and captures the opening 160 bits of every packet, which covers the header and the start of the payload. It compares that head against four programmable comparison entries and issues one routing verdict per packet. The verdict is one of three: forward the packet normally, forward it and send a copy to a selected trace port, or drop it.

Each entry holds a 160-bit pattern, a 160-bit care mask, an enable bit and an action bit that picks drop or trace. A global enable switches the whole feature off. When the feature is off, or no enabled entry matches, the verdict is plain forwarding. The compare runs one word at a time as the words arrive, so the block keeps pace with the line and needs no head buffer. One instance is placed on each port, and the instances run independently of one another.

Top module: `trace_head_matcher`

## Requirements
- R1: The comparison window is the first five words of a packet. The word carrying rx_sop is compared with entry bits 159:128, and word k (counting from 0) is compared with bits 159-32k down to 128-32k. Words after the fifth have no effect on the verdict.
- R2: A window bit takes part in an entry's comparison only where that entry's cfg_mask bit is 1. An enabled entry whose mask is all zero matches every packet.
- R3: An entry whose cfg_entry_en bit is 0 never matches.
- R4: dec_action encodes the verdict as 0 = forward, 1 = forward plus trace copy, 2 = drop. A matching entry whose cfg_entry_drop bit is 1 asks for drop; one whose bit is 0 asks for trace. The value 3 never appears.
- R5: With cfg_trace_en low, every verdict is 0 (forward).
- R6: dec_trace_port equals cfg_trace_port when dec_action is 1, and is 0 for any other verdict.
- R7: When several enabled entries match, drop wins over trace.
- R8: Every packet of five or more words produces exactly one dec_valid pulse, one cycle wide. It appears in the cycle after the edge that accepts the fifth word.
- R9: A packet that ends (rx_eop) before its fifth word produces its single pulse in the cycle after the edge that accepts the end word. Window bits that never arrived count as don't-care.
- R10: Cycles with rx_valid low, and words that arrive outside a packet (after rx_eop and before the next rx_sop), change nothing and produce no pulse. Idle gaps inside a packet do not disturb the word count.
- R11: While rst_n is low, dec_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A word is present on rx_data |
| rx_sop | input | 1 | First word of a packet |
| rx_eop | input | 1 | Last word of a packet |
| rx_data | input | 32 | Packet word |
| cfg_trace_en | input | 1 | Global enable for matching |
| cfg_entry_en | input | 4 | Per-entry enable |
| cfg_entry_drop | input | 4 | Per-entry action, 1 = drop, 0 = trace |
| cfg_value | input | 640 | Entry patterns, entry e in bits 160e+159:160e |
| cfg_mask | input | 640 | Entry care masks, same layout as cfg_value |
| cfg_trace_port | input | 3 | Index of the port that receives trace copies |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_action | output | 2 | Verdict code |
| dec_trace_port | output | 3 | Trace destination, valid with verdict 1 |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 160-bit window, four entries and eight ports. The window is therefore five words, so packets of one to eight words reach the short case, the exact-length case and the case where words fall past the window. This also puts the decision index, word 4, inside a single 3-bit counter. Four entries are enough to have a drop entry and a trace entry match the same packet, and to pair a disabled entry with an all-zero mask. A randomized pass draws entry patterns from the packet's own words with sparse masks, so matches of every kind are common, and it compares each verdict with a model in the bench.

// File: rtl/thm_pkg.sv
package thm_pkg;
   typedef enum logic [1:0] {
      ACT_FWD   = 2'd0,
      ACT_TRACE = 2'd1,
      ACT_DROP  = 2'd2
   } act_e;
endpackage

// File: rtl/thm_word_track.sv
module thm_word_track #(
   parameter int WIN_WORDS = 5,
   parameter int IDX_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic             rx_sop,
   input  logic             rx_eop,
   output logic             word_fire,
   output logic             first,
   output logic [IDX_W-1:0] cur_idx,
   output logic             decide
);
   logic             in_pkt;
   logic             done;
   logic [IDX_W-1:0] word_idx;

   assign first     = rx_valid && rx_sop;
   assign cur_idx   = rx_sop ? '0 : word_idx;
   assign word_fire = first || (rx_valid && in_pkt && !done);
   assign decide    = word_fire && (rx_eop || (cur_idx == IDX_W'(WIN_WORDS-1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_pkt   <= 1'b0;
         done     <= 1'b0;
         word_idx <= '0;
      end else if (rx_valid && (rx_sop || in_pkt)) begin
         in_pkt <= !rx_eop;
         done   <= rx_sop ? decide : (done || decide);
         if (word_fire && !decide)
            word_idx <= cur_idx + 1'b1;
      end
   end
endmodule

// File: rtl/thm_entry_cmp.sv
module thm_entry_cmp #(
   parameter int DATA_W    = 32,
   parameter int WIN_BITS  = 160,
   parameter int WIN_WORDS = 5,
   parameter int IDX_W     = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                word_fire,
   input  logic                first,
   input  logic [IDX_W-1:0]    cur_idx,
   input  logic [DATA_W-1:0]   rx_data,
   input  logic [WIN_BITS-1:0] value,
   input  logic [WIN_BITS-1:0] mask,
   output logic                hit
);
   logic [DATA_W-1:0] val_sl [WIN_WORDS];
   logic [DATA_W-1:0] msk_sl [WIN_WORDS];
   logic [DATA_W-1:0] val_cur;
   logic [DATA_W-1:0] msk_cur;
   logic              run_ok;
   logic              word_ok;

   for (genvar k = 0; k < WIN_WORDS; k++) begin : g_slice
      assign val_sl[k] = value[WIN_BITS-1-k*DATA_W -: DATA_W];
      assign msk_sl[k] = mask [WIN_BITS-1-k*DATA_W -: DATA_W];
   end

   always_comb begin
      val_cur = '0;
      msk_cur = '0;
      for (int k = 0; k < WIN_WORDS; k++) begin
         if (cur_idx == IDX_W'(k)) begin
            val_cur = val_sl[k];
            msk_cur = msk_sl[k];
         end
      end
   end

   assign word_ok = ((rx_data ^ val_cur) & msk_cur) == '0;
   assign hit     = (first || run_ok) && word_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_ok <= 1'b0;
      else if (word_fire)
         run_ok <= hit;
   end
endmodule

// File: rtl/thm_action_resolve.sv
module thm_action_resolve
   import thm_pkg::*;
#(
   parameter int N_ENTRY = 4,
   parameter int PORT_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               decide,
   input  logic [N_ENTRY-1:0] hits,
   input  logic [N_ENTRY-1:0] entry_en,
   input  logic [N_ENTRY-1:0] entry_drop,
   input  logic               trace_en,
   input  logic [PORT_W-1:0]  trace_port,
   output logic               dec_valid,
   output act_e               dec_action,
   output logic [PORT_W-1:0]  dec_port
);
   logic [N_ENTRY-1:0] live;
   logic               any_drop;
   logic               any_trace;
   act_e               verdict;

   assign live      = hits & entry_en & {N_ENTRY{trace_en}};
   assign any_drop  = |(live & entry_drop);
   assign any_trace = |(live & ~entry_drop);

   always_comb begin
      if (any_drop)       verdict = ACT_DROP;
      else if (any_trace) verdict = ACT_TRACE;
      else                verdict = ACT_FWD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_action <= ACT_FWD;
         dec_port   <= '0;
      end else begin
         dec_valid <= decide;
         if (decide) begin
            dec_action <= verdict;
            dec_port   <= (verdict == ACT_TRACE) ? trace_port : '0;
         end
      end
   end
endmodule

// File: rtl/trace_head_matcher.sv
module trace_head_matcher
   import thm_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int WIN_BITS = 160,
   parameter int N_ENTRY  = 4,
   parameter int N_PORTS  = 8,
   localparam int WIN_WORDS = WIN_BITS / DATA_W,
   localparam int IDX_W     = $clog2(WIN_WORDS + 1),
   localparam int PORT_W    = $clog2(N_PORTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rx_valid,
   input  logic                        rx_sop,
   input  logic                        rx_eop,
   input  logic [DATA_W-1:0]           rx_data,
   input  logic                        cfg_trace_en,
   input  logic [N_ENTRY-1:0]          cfg_entry_en,
   input  logic [N_ENTRY-1:0]          cfg_entry_drop,
   input  logic [N_ENTRY*WIN_BITS-1:0] cfg_value,
   input  logic [N_ENTRY*WIN_BITS-1:0] cfg_mask,
   input  logic [PORT_W-1:0]           cfg_trace_port,
   output logic                        dec_valid,
   output logic [1:0]                  dec_action,
   output logic [PORT_W-1:0]           dec_trace_port
);
   if (WIN_BITS % DATA_W != 0) begin : g_bad_win
      $error("window width must be a whole number of words");
   end
   if (WIN_WORDS < 2) begin : g_bad_depth
      $error("window must span at least two words");
   end
   if (N_ENTRY < 1) begin : g_bad_entry
      $error("at least one comparison entry is needed");
   end
   if (N_PORTS < 2) begin : g_bad_ports
      $error("trace port index needs at least two ports");
   end

   logic               word_fire;
   logic               first;
   logic [IDX_W-1:0]   cur_idx;
   logic               decide;
   logic [N_ENTRY-1:0] hits;
   act_e               act_q;

   thm_word_track #(.WIN_WORDS(WIN_WORDS), .IDX_W(IDX_W)) i_track (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop),
      .rx_eop(rx_eop), .word_fire(word_fire), .first(first),
      .cur_idx(cur_idx), .decide(decide)
   );

   for (genvar e = 0; e < N_ENTRY; e++) begin : g_entry
      thm_entry_cmp #(
         .DATA_W(DATA_W), .WIN_BITS(WIN_BITS),
         .WIN_WORDS(WIN_WORDS), .IDX_W(IDX_W)
      ) i_cmp (
         .clk(clk), .rst_n(rst_n), .word_fire(word_fire), .first(first),
         .cur_idx(cur_idx), .rx_data(rx_data),
         .value(cfg_value[e*WIN_BITS +: WIN_BITS]),
         .mask(cfg_mask[e*WIN_BITS +: WIN_BITS]),
         .hit(hits[e])
      );
   end

   thm_action_resolve #(.N_ENTRY(N_ENTRY), .PORT_W(PORT_W)) i_resolve (
      .clk(clk), .rst_n(rst_n), .decide(decide), .hits(hits),
      .entry_en(cfg_entry_en), .entry_drop(cfg_entry_drop),
      .trace_en(cfg_trace_en), .trace_port(cfg_trace_port),
      .dec_valid(dec_valid), .dec_action(act_q), .dec_port(dec_trace_port)
   );

   assign dec_action = act_q;
endmodule

// File: rtl/thm_checker.sv
module thm_checker #(
   parameter int PORT_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              rx_sop,
   input logic              cfg_trace_en,
   input logic              dec_valid,
   input logic [1:0]        dec_action,
   input logic [PORT_W-1:0] dec_trace_port
);
   logic seen_sop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  seen_sop <= 1'b0;
      else if (rx_valid && rx_sop) seen_sop <= 1'b1;
   end

   // R4: no undefined verdict code
   a_r4_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> dec_action != 2'd3);

   // R5: feature off means plain forwarding
   a_r5_off_forwards: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !$past(cfg_trace_en)) |-> dec_action == 2'd0);

   // R6: trace port only accompanies a trace verdict
   a_r6_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_action != 2'd1) |-> dec_trace_port == '0);

   // R10: a verdict follows an accepted word
   a_r10_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(rx_valid));

   // R10: no verdict before any packet has started
   a_r10_needs_sop: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> seen_sop);

   // R11: quiet during reset
   a_r11_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> !dec_valid);
endmodule

bind trace_head_matcher thm_checker #(.PORT_W(PORT_W)) i_thm_checker (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop),
   .cfg_trace_en(cfg_trace_en), .dec_valid(dec_valid),
   .dec_action(dec_action), .dec_trace_port(dec_trace_port)
);

// File: tb/test_trace_head_matcher.sv
`timescale 1ns/1ps
module test_trace_head_matcher;
   localparam int WB = 160;
   localparam int NE = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
   logic [31:0]   rx_data = '0;
   logic          cfg_trace_en = 1'b0;
   logic [NE-1:0] cfg_entry_en = '0, cfg_entry_drop = '0;
   logic [NE*WB-1:0] cfg_value = '0, cfg_mask = '0;
   logic [2:0]    cfg_trace_port = '0;
   logic          dec_valid;
   logic [1:0]    dec_action;
   logic [2:0]    dec_trace_port;

   int n_chk = 0, n_bad = 0;
   logic [31:0] pkt_w [16];

   always #4 clk = ~clk;

   trace_head_matcher i_trace_head_matcher (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop),
      .rx_eop(rx_eop), .rx_data(rx_data), .cfg_trace_en(cfg_trace_en),
      .cfg_entry_en(cfg_entry_en), .cfg_entry_drop(cfg_entry_drop),
      .cfg_value(cfg_value), .cfg_mask(cfg_mask),
      .cfg_trace_port(cfg_trace_port), .dec_valid(dec_valid),
      .dec_action(dec_action), .dec_trace_port(dec_trace_port)
   );

   task automatic chk(input bit ok, input string req, input longint act,
                      input longint exp, input string what);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [WB-1:0] head_of();
      return {pkt_w[0], pkt_w[1], pkt_w[2], pkt_w[3], pkt_w[4]};
   endfunction

   task automatic set_entry(input int e, input logic [WB-1:0] v,
                            input logic [WB-1:0] m, input bit en, input bit drp);
      cfg_value[e*WB +: WB] = v;
      cfg_mask[e*WB +: WB]  = m;
      cfg_entry_en[e]       = en;
      cfg_entry_drop[e]     = drp;
   endtask

   task automatic clear_entries();
      for (int e = 0; e < NE; e++) set_entry(e, '0, '0, 1'b0, 1'b0);
   endtask

   // verdict model from R1..R7, R9
   function automatic logic [1:0] model(input int n);
      bit d = 0, t = 0;
      int lim = (n < 5) ? n : 5;
      for (int e = 0; e < NE; e++) begin
         bit h = cfg_entry_en[e];
         for (int w = 0; w < lim; w++)
            if (((pkt_w[w] ^ cfg_value[e*WB + WB-1-32*w -: 32]) &
                 cfg_mask[e*WB + WB-1-32*w -: 32]) != 0) h = 0;
         if (h && cfg_trace_en) begin
            if (cfg_entry_drop[e]) d = 1; else t = 1;
         end
      end
      return d ? 2'd2 : (t ? 2'd1 : 2'd0);
   endfunction

   task automatic fill_pkt(input int n);
      for (int i = 0; i < n; i++) pkt_w[i] = $urandom;
   endtask

   // send a packet, check pulse count, position, verdict and port
   task automatic run_pkt(input int n, input bit gaps, input string req);
      int ndec = 0, at = -1;
      logic [1:0] act = '0, exp_act;
      logic [2:0] port = '0;
      int exp_at = (n < 5) ? n-1 : 4;
      exp_act = model(n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_sop = (i == 0); rx_eop = (i == n-1);
         rx_data = pkt_w[i];
         @(posedge clk); #2;
         if (dec_valid) begin ndec++; at = i; act = dec_action; port = dec_trace_port; end
         if (gaps && i != n-1) begin
            @(negedge clk); rx_valid = 1'b0; rx_data = $urandom;
            @(posedge clk); #2;
            if (dec_valid) ndec++;
         end
      end
      @(negedge clk); rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
      @(posedge clk); #2;
      if (dec_valid) ndec++;
      chk(ndec == 1, "R8", ndec, 1, {req, " pulse count"});
      chk(at == exp_at, (n < 5) ? "R9" : "R8", at, exp_at, {req, " pulse word"});
      chk(act == exp_act, req, act, exp_act, {req, " verdict"});
      chk(port == ((exp_act == 2'd1) ? cfg_trace_port : 3'd0), "R6", port,
          (exp_act == 2'd1) ? cfg_trace_port : 3'd0, {req, " trace port"});
   endtask

   task automatic t_reset();
      chk(dec_valid == 1'b0, "R11", dec_valid, 0, "dec_valid in reset");
   endtask

   task automatic t_no_match();
      clear_entries(); cfg_trace_en = 1'b1;
      fill_pkt(6);
      set_entry(0, ~head_of(), '1, 1'b1, 1'b0);
      run_pkt(6, 0, "R4 no match forward");
   endtask

   task automatic t_trace();
      clear_entries(); cfg_trace_en = 1'b1; cfg_trace_port = 3'd5;
      fill_pkt(5);
      set_entry(1, head_of(), '1, 1'b1, 1'b0);
      run_pkt(5, 0, "R4 exact trace");
      chk(model(5) == 2'd1, "R1", model(5), 1, "trace expected");
   endtask

   task automatic t_drop();
      clear_entries(); cfg_trace_en = 1'b1; cfg_trace_port = 3'd6;
      fill_pkt(7);
      set_entry(2, head_of(), '1, 1'b1, 1'b1);
      run_pkt(7, 0, "R4 exact drop");
   endtask

   task automatic t_priority();
      clear_entries(); cfg_trace_en = 1'b1; cfg_trace_port = 3'd3;
      fill_pkt(5);
      set_entry(0, head_of(), '1, 1'b1, 1'b0);
      set_entry(3, head_of(), {32'hFFFF_0000, 128'd0}, 1'b1, 1'b1);
      run_pkt(5, 0, "R7 drop over trace");
   endtask

   task automatic t_mask();
      logic [WB-1:0] v;
      clear_entries(); cfg_trace_en = 1'b1; cfg_trace_port = 3'd1;
      fill_pkt(5);
      v = head_of() ^ {32'h0000_00FF, 128'd0};
      set_entry(0, v, {32'hFFFF_FF00, {128{1'b1}}}, 1'b1, 1'b0);
      run_pkt(5, 0, "R2 masked bits ignored");
      clear_entries();
      set_entry(1, '0, '0, 1'b1, 1'b0);
      fill_pkt(3);
      run_pkt(3, 0, "R2 zero mask matches");
   endtask

   task automatic t_disabled();
      clear_entries(); cfg_trace_en = 1'b1;
      fill_pkt(5);
      set_entry(0, head_of(), '1, 1'b0, 1'b1);
      set_entry(1, '0, '0, 1'b0, 1'b0);
      run_pkt(5, 0, "R3 disabled entries");
   endtask

   task automatic t_global_off();
      clear_entries(); cfg_trace_en = 1'b0;
      fill_pkt(5);
      set_entry(0, head_of(), '1, 1'b1, 1'b1);
      run_pkt(5, 0, "R5 feature off");
   endtask

   task automatic t_late_words();
      clear_entries(); cfg_trace_en = 1'b1; cfg_trace_port = 3'd7;
      fill_pkt(9);
      set_entry(0, head_of(), '1, 1'b1, 1'b0);
      run_pkt(9, 0, "R1 words past window ignored");
   endtask

   task automatic t_short();
      clear_entries(); cfg_trace_en = 1'b1; cfg_trace_port = 3'd2;
      fill_pkt(5);
      set_entry(0, head_of(), '1, 1'b1, 1'b0);
      pkt_w[2] = ~pkt_w[2];
      run_pkt(2, 0, "R9 short packet missing bits dont care");
      run_pkt(1, 0, "R9 single word packet");
   endtask

   task automatic t_framing();
      int stray = 0;
      clear_entries(); cfg_trace_en = 1'b1; cfg_trace_port = 3'd4;
      set_entry(0, '0, '0, 1'b1, 1'b0);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); rx_valid = 1'b1; rx_sop = 1'b0; rx_eop = (i == 5);
         rx_data = $urandom;
         @(posedge clk); #2;
         if (dec_valid) stray++;
      end
      @(negedge clk); rx_valid = 1'b0; rx_eop = 1'b0;
      @(posedge clk); #2;
      if (dec_valid) stray++;
      chk(stray == 0, "R10", stray, 0, "words outside packet");
      fill_pkt(6);
      set_entry(1, head_of(), '1, 1'b1, 1'b1);
      run_pkt(6, 1, "R10 gaps inside packet");
   endtask

   task automatic t_random();
      for (int p = 0; p < 200; p++) begin
         int n = 1 + ($urandom % 8);
         fill_pkt(n);
         for (int i = n; i < 5; i++) pkt_w[i] = $urandom;
         cfg_trace_en   = ($urandom % 8) != 0;
         cfg_trace_port = 3'($urandom);
         for (int e = 0; e < NE; e++) begin
            logic [WB-1:0] v = head_of(), m = '0;
            for (int b = 0; b < 5; b++) begin
               m[WB-1-32*b -: 32] = $urandom & $urandom & $urandom;
               if ($urandom % 6 == 0) v[WB-1-32*b -: 32] ^= 32'(1 << ($urandom % 32));
            end
            set_entry(e, v, m, ($urandom % 4) != 0, $urandom % 2);
         end
         run_pkt(n, $urandom % 2, "R7 random");
      end
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2; t_reset();
      @(negedge clk); rst_n = 1'b1;
      t_no_match();
      t_trace();
      t_drop();
      t_priority();
      t_mask();
      t_disabled();
      t_global_off();
      t_late_words();
      t_short();
      t_framing();
      t_random();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule